// File: doc/BRIEF.md
# Packet Buffer Pointer Data Port

This block lets a host CPU reach packet buffer memory indirectly. The host first loads a 16-bit pointer word that holds a byte offset together with three control bits: an area select (receive or transmit), an auto-increment enable and a transfer direction. It then moves bytes or words through a data register. Each memory byte is addressed by a packet number joined to the pointer offset. The packet number comes from the head of the receive FIFO when the receive area is selected, and from the transmit packet number register otherwise.

Reads are served from a small prefetch queue. A pointer load in read direction flushes the queue and restarts fetching at the new offset. Writes are posted into a small write queue that drains one byte per cycle into the internal synchronous RAM. The ready output holds a data read until the requested bytes are queued, and holds a pointer load until all posted writes have reached memory. Pointer read-back shows the offset the host last consumed, not where the prefetcher has got to. An interrupt handler can therefore save and restore the pointer safely.

The host interface is a single-cycle strobe. `hst_cs` is held with the other request inputs, and the transfer completes on the first rising clock edge where both `hst_cs` and `hst_rdy` are high. `hst_rdata` is valid in that same cycle.

Top module: `pdp_top`

## Requirements
- R1: After reset the pointer reads back as 0x0000, `ptr_err` is low, and `hst_rdy` is high while no access is requested.
- R2: Pointer word layout: bit 15 is the receive-area select, bit 14 is auto-increment, bit 13 is the read direction, and bits OFF_W-1:0 are the offset. Every other bit reads as zero and ignores writes.
- R3: A pointer write with only the low lane enabled (`hst_be`=01) stores the low byte without changing the pointer. A write with only the high lane (`hst_be`=10) then commits {high byte, stored low byte}. A word write (`hst_be`=11) commits the whole value.
- R4: A pointer write is held not-ready until the write queue is empty.
- R5: A data read in read direction returns, for `hst_be`=11, the byte at the offset on bits 7:0 and the byte at offset+1 on bits 15:8. For `hst_be`=01 it returns the byte at the offset on bits 7:0 with the rest zero; for `hst_be`=10 it returns that byte on bits 15:8 with the rest zero. Ready stays low until the bytes are present.
- R6: With auto-increment set, each data access advances the offset by 1 for a byte access and by 2 for a word access, wrapping modulo 2^OFF_W.
- R7: With auto-increment clear, data accesses leave the offset unchanged. Repeated reads return the same data, and repeated writes overwrite the same location.
- R8: Pointer read-back returns the offset following the last data access by the host, regardless of how far the prefetcher has fetched.
- R9: The packet number used for each memory byte is `rx_head_pkt` when the area select bit is set and `tx_pkt_num` when it is clear.
- R10: A data access whose `hst_we` disagrees with the direction bit completes at once, returns zero and changes neither the pointer nor the memory.
- R11: Committing a pointer with auto-increment clear and an odd offset raises `ptr_err`. The flag holds until the next commit, which recomputes it.
- R12: A pointer load discards any previously prefetched data, so the next read returns data from the new offset.
- R13: Data writes are posted: a write completes without waiting whenever the write queue has room for its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_cs | input | 1 | Host access request, held until accepted |
| hst_dsel | input | 1 | 1 selects the data register, 0 the pointer register |
| hst_we | input | 1 | 1 for a host write, 0 for a host read |
| hst_be | input | 2 | Byte lane enables (01 low, 10 high, 11 word) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid when the access is accepted |
| hst_rdy | output | 1 | Access can complete on this clock edge |
| rx_head_pkt | input | PKT_W | Packet number at the head of the receive FIFO |
| tx_pkt_num | input | PKT_W | Transmit packet number register |
| ptr_err | output | 1 | Odd offset committed with auto-increment off |

## Verification
The bench builds the block with a 6-bit offset and a 2-bit packet number, while both queue depths stay at 4. The short offset makes wraparound from 63 to 0 reachable with a single word access. The wider packet number lets two different packets hold distinct data at the same offset, so a wrong area selection shows up as wrong data. Queue depths of 4 let a single pair of word writes fill the write queue, which exposes the pointer-load stall.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

    localparam int PTR_W     = 16;
    localparam int RCV_BIT   = 15;
    localparam int AUTO_BIT  = 14;
    localparam int DIR_BIT   = 13;

    typedef struct packed {
        logic rcv;
        logic auto_inc;
        logic rd;
    } ptr_ctl_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_PTR_WR,
        ACC_PTR_RD,
        ACC_DAT_RD,
        ACC_DAT_WR,
        ACC_SKIP
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic cs, input logic is_data,
                                           input logic we, input logic dir_rd);
        if (!cs)              return ACC_IDLE;
        else if (!is_data)    return we ? ACC_PTR_WR : ACC_PTR_RD;
        else if (we == dir_rd) return ACC_SKIP;
        else                  return we ? ACC_DAT_WR : ACC_DAT_RD;
    endfunction

    function automatic logic [1:0] lane_bytes(input logic [1:0] be);
        return (be == 2'b01 || be == 2'b10) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/pdp_byteq.sv
module pdp_byteq #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_d0,
    input  logic [W-1:0]  push_d1,
    input  logic [1:0]    pop_n,
    output logic [W-1:0]  front0,
    output logic [W-1:0]  front1,
    output logic [CW-1:0] cnt
);
    localparam logic [AW-1:0] IDX_ONE = 1;

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] rd_idx;
    logic [AW-1:0] wr_idx;
    logic [CW-1:0] fill;

    assign wr_idx = rd_idx + fill[AW-1:0];
    assign front0 = slots[rd_idx];
    assign front1 = slots[rd_idx + IDX_ONE];
    assign cnt    = fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0;
            fill   <= '0;
        end else if (flush) begin
            fill   <= '0;
        end else begin
            rd_idx <= rd_idx + AW'(pop_n);
            fill   <= fill + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push_n != 2'd0) slots[wr_idx]           <= push_d0;
            if (push_n == 2'd2) slots[wr_idx + IDX_ONE] <= push_d1;
        end
    end

endmodule

// File: rtl/pdp_ptr.sv
module pdp_ptr
    import pdp_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_data,
    input  logic             adv_fire,
    input  logic [1:0]       adv_n,
    output logic [OFF_W-1:0] off,
    output ptr_ctl_t         ctl,
    output logic             err,
    output logic             commit,
    output logic [15:0]      rdback
);
    logic [7:0]  lo_stage;
    logic [15:0] new_word;

    assign commit   = wr_fire && (wr_be != 2'b01);
    assign new_word = (wr_be == 2'b10) ? {wr_data[15:8], lo_stage} : wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            off      <= '0;
            ctl      <= '0;
            err      <= 1'b0;
            lo_stage <= '0;
        end else begin
            if (wr_fire && wr_be == 2'b01) lo_stage <= wr_data[7:0];
            if (commit) begin
                off          <= new_word[OFF_W-1:0];
                ctl.rcv      <= new_word[RCV_BIT];
                ctl.auto_inc <= new_word[AUTO_BIT];
                ctl.rd       <= new_word[DIR_BIT];
                err          <= !new_word[AUTO_BIT] && new_word[0];
            end else if (adv_fire) begin
                off <= off + OFF_W'(adv_n);
            end
        end
    end

    always_comb begin
        rdback             = '0;
        rdback[OFF_W-1:0]  = off;
        rdback[RCV_BIT]    = ctl.rcv;
        rdback[AUTO_BIT]   = ctl.auto_inc;
        rdback[DIR_BIT]    = ctl.rd;
    end

endmodule

// File: rtl/pdp_mem.sv
module pdp_mem #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [2**AW];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        if (re) rdata <= cells[raddr];
    end

endmodule

// File: rtl/pdp_prefetch.sv
module pdp_prefetch #(
    parameter int OFF_W = 11,
    parameter int PKT_W = 1,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   restart,
    input  logic [OFF_W-1:0]       start_off,
    input  logic [PKT_W-1:0]       pkt,
    input  logic [1:0]             pop_n,
    input  logic [7:0]             mem_rdata,
    output logic                   mem_re,
    output logic [PKT_W+OFF_W-1:0] mem_raddr,
    output logic [7:0]             front0,
    output logic [7:0]             front1,
    output logic [CW-1:0]          cnt
);
    localparam logic [OFF_W-1:0] OFF_ONE = 1;

    logic [OFF_W-1:0] fetch_off;
    logic             reload;
    logic             inflight;
    logic             issue;
    logic [1:0]       push_n;

    assign issue     = enable && !reload && !restart &&
                       ((cnt + CW'(inflight)) < CW'(DEPTH));
    assign mem_re    = issue;
    assign mem_raddr = {pkt, fetch_off};
    assign push_n    = (inflight && !restart) ? 2'd1 : 2'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_off <= '0;
            reload    <= 1'b0;
            inflight  <= 1'b0;
        end else if (restart) begin
            reload    <= 1'b1;
            inflight  <= 1'b0;
        end else if (reload) begin
            fetch_off <= start_off;
            reload    <= 1'b0;
            inflight  <= 1'b0;
        end else begin
            inflight  <= issue;
            if (issue) fetch_off <= fetch_off + OFF_ONE;
        end
    end

    pdp_byteq #(.W(8), .DEPTH(DEPTH)) u_q (
        .clk     (clk),
        .rst     (rst),
        .flush   (restart),
        .push_n  (push_n),
        .push_d0 (mem_rdata),
        .push_d1 (mem_rdata),
        .pop_n   (pop_n),
        .front0  (front0),
        .front1  (front1),
        .cnt     (cnt)
    );

endmodule

// File: rtl/pdp_top.sv
module pdp_top
    import pdp_pkg::*;
#(
    parameter int OFF_W     = 11,
    parameter int PKT_W     = 1,
    parameter int PFQ_DEPTH = 4,
    parameter int WRQ_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hst_cs,
    input  logic             hst_dsel,
    input  logic             hst_we,
    input  logic [1:0]       hst_be,
    input  logic [15:0]      hst_wdata,
    output logic [15:0]      hst_rdata,
    output logic             hst_rdy,
    input  logic [PKT_W-1:0] rx_head_pkt,
    input  logic [PKT_W-1:0] tx_pkt_num,
    output logic             ptr_err
);
    localparam int MEM_AW = OFF_W + PKT_W;
    localparam int WQ_W   = MEM_AW + 8;
    localparam int PF_CW  = $clog2(PFQ_DEPTH) + 1;
    localparam int WQ_CW  = $clog2(WRQ_DEPTH) + 1;
    localparam logic [OFF_W-1:0] OFF_ONE = 1;

    acc_kind_e        kind;
    logic [1:0]       nbytes;
    logic             is_word;
    logic             fire;
    logic             fire_ptr_wr, fire_rd, fire_wr, fire_skip;
    logic [OFF_W-1:0] ptr_off;
    ptr_ctl_t         ctl;
    logic             ptr_commit;
    logic [15:0]      ptr_rdback;
    logic             auto_on;
    logic [PKT_W-1:0] pkt_sel;

    logic [PF_CW-1:0] pf_cnt;
    logic [7:0]       pf_b0, pf_b1;
    logic [1:0]       pf_pop;
    logic             pf_restart;
    logic             mem_re;
    logic [MEM_AW-1:0] mem_raddr;
    logic [7:0]       mem_rdata;

    logic [WQ_CW-1:0] wq_cnt;
    logic [WQ_CW-1:0] wq_free;
    logic [1:0]       wq_push;
    logic [WQ_W-1:0]  wq_d0, wq_d1, wq_head, wq_unused;
    logic [1:0]       wq_pop;
    logic [7:0]       wr_lo, wr_hi;

    assign kind    = classify(hst_cs, hst_dsel, hst_we, ctl.rd);
    assign nbytes  = lane_bytes(hst_be);
    assign is_word = (nbytes == 2'd2);
    assign auto_on = ctl.auto_inc;
    assign pkt_sel = ctl.rcv ? rx_head_pkt : tx_pkt_num;
    assign wq_free = WQ_CW'(WRQ_DEPTH) - wq_cnt;

    always_comb begin
        case (kind)
            ACC_PTR_WR: hst_rdy = (wq_cnt == '0);
            ACC_DAT_RD: hst_rdy = (pf_cnt >= PF_CW'(nbytes));
            ACC_DAT_WR: hst_rdy = (wq_free >= WQ_CW'(nbytes));
            default:    hst_rdy = 1'b1;
        endcase
    end

    assign fire        = hst_cs && hst_rdy;
    assign fire_ptr_wr = fire && (kind == ACC_PTR_WR);
    assign fire_rd     = fire && (kind == ACC_DAT_RD);
    assign fire_wr     = fire && (kind == ACC_DAT_WR);
    assign fire_skip   = fire && (kind == ACC_SKIP);

    pdp_ptr #(.OFF_W(OFF_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .wr_fire  (fire_ptr_wr),
        .wr_be    (hst_be),
        .wr_data  (hst_wdata),
        .adv_fire ((fire_rd || fire_wr) && auto_on),
        .adv_n    (nbytes),
        .off      (ptr_off),
        .ctl      (ctl),
        .err      (ptr_err),
        .commit   (ptr_commit),
        .rdback   (ptr_rdback)
    );

    // Prefetch side: restart on any commit, or after each read when the pointer holds still.
    assign pf_restart = ptr_commit || (fire_rd && !auto_on);
    assign pf_pop     = (fire_rd && auto_on) ? nbytes : 2'd0;

    pdp_prefetch #(.OFF_W(OFF_W), .PKT_W(PKT_W), .DEPTH(PFQ_DEPTH)) u_pf (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctl.rd),
        .restart   (pf_restart),
        .start_off (ptr_off),
        .pkt       (pkt_sel),
        .pop_n     (pf_pop),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .front0    (pf_b0),
        .front1    (pf_b1),
        .cnt       (pf_cnt)
    );

    // Posted write side: each entry is {packet, offset, byte}.
    assign wr_lo   = (hst_be == 2'b10) ? hst_wdata[15:8] : hst_wdata[7:0];
    assign wr_hi   = hst_wdata[15:8];
    assign wq_d0   = {pkt_sel, ptr_off, wr_lo};
    assign wq_d1   = {pkt_sel, ptr_off + OFF_ONE, wr_hi};
    assign wq_push = fire_wr ? nbytes : 2'd0;
    assign wq_pop  = (wq_cnt != '0) ? 2'd1 : 2'd0;

    pdp_byteq #(.W(WQ_W), .DEPTH(WRQ_DEPTH)) u_wq (
        .clk     (clk),
        .rst     (rst),
        .flush   (1'b0),
        .push_n  (wq_push),
        .push_d0 (wq_d0),
        .push_d1 (wq_d1),
        .pop_n   (wq_pop),
        .front0  (wq_head),
        .front1  (wq_unused),
        .cnt     (wq_cnt)
    );

    pdp_mem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (wq_pop[0]),
        .waddr (wq_head[WQ_W-1:8]),
        .wdata (wq_head[7:0]),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        case (kind)
            ACC_PTR_RD: hst_rdata = ptr_rdback;
            ACC_DAT_RD: begin
                case (hst_be)
                    2'b01:   hst_rdata = {8'h00, pf_b0};
                    2'b10:   hst_rdata = {pf_b0, 8'h00};
                    default: hst_rdata = {pf_b1, pf_b0};
                endcase
            end
            default:    hst_rdata = 16'h0000;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^wq_unused;

endmodule

// File: rtl/pdp_chk.sv
module pdp_chk #(
    parameter int OFF_W     = 11,
    parameter int PFQ_DEPTH = 4,
    parameter int WRQ_DEPTH = 4,
    localparam int PF_CW    = $clog2(PFQ_DEPTH) + 1,
    localparam int WQ_CW    = $clog2(WRQ_DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             fire_ptr_wr,
    input logic             fire_rd,
    input logic             fire_wr,
    input logic             fire_skip,
    input logic             is_word,
    input logic             auto_on,
    input logic [OFF_W-1:0] ptr_off,
    input logic             ptr_err,
    input logic             ptr_commit,
    input logic [PF_CW-1:0] pf_cnt,
    input logic [WQ_CW-1:0] wq_cnt
);
    AST_PTR_LOAD_DRAINED: assert property (@(posedge clk) disable iff (rst)
        fire_ptr_wr |-> (wq_cnt == '0)); // R4

    AST_PFQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        pf_cnt <= PF_CW'(PFQ_DEPTH)); // R5

    AST_WQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        wq_cnt <= WQ_CW'(WRQ_DEPTH)); // R13

    AST_ADV_WORD: assert property (@(posedge clk) disable iff (rst)
        ((fire_rd || fire_wr) && auto_on && is_word) |=>
            ((ptr_off - $past(ptr_off)) == OFF_W'(2))); // R6

    AST_ADV_BYTE: assert property (@(posedge clk) disable iff (rst)
        ((fire_rd || fire_wr) && auto_on && !is_word) |=>
            ((ptr_off - $past(ptr_off)) == OFF_W'(1))); // R6

    AST_NOAUTO_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((fire_rd || fire_wr) && !auto_on) |=> $stable(ptr_off)); // R7

    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        fire_skip |=> $stable(ptr_off)); // R10

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ptr_commit |=> $stable(ptr_err)); // R11

    AST_FLUSH_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        ptr_commit |=> (pf_cnt == '0)); // R12

endmodule

bind pdp_top pdp_chk #(
    .OFF_W     (OFF_W),
    .PFQ_DEPTH (PFQ_DEPTH),
    .WRQ_DEPTH (WRQ_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fire_ptr_wr (fire_ptr_wr),
    .fire_rd     (fire_rd),
    .fire_wr     (fire_wr),
    .fire_skip   (fire_skip),
    .is_word     (is_word),
    .auto_on     (auto_on),
    .ptr_off     (ptr_off),
    .ptr_err     (ptr_err),
    .ptr_commit  (ptr_commit),
    .pf_cnt      (pf_cnt),
    .wq_cnt      (wq_cnt)
);

// File: tb/pdp_top_tb.sv
module pdp_top_tb;
    localparam int OFF_W = 6;
    localparam int PKT_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs = 1'b0, dsel = 1'b0, we = 1'b0;
    logic [1:0]       be = 2'b11;
    logic [15:0]      wdata = '0;
    logic [15:0]      rdata;
    logic             rdy;
    logic [PKT_W-1:0] rxh = '0, txp = '0;
    logic             err;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pdp_top #(.OFF_W(OFF_W), .PKT_W(PKT_W)) u_dut (
        .clk(clk), .rst(rst), .hst_cs(cs), .hst_dsel(dsel), .hst_we(we),
        .hst_be(be), .hst_wdata(wdata), .hst_rdata(rdata), .hst_rdy(rdy),
        .rx_head_pkt(rxh), .tx_pkt_num(txp), .ptr_err(err)
    );

    function automatic logic [7:0] bv(input int o);
        return 8'(o) ^ 8'h5A;
    endfunction

    function automatic logic [15:0] pw(input bit r, input bit a, input bit d, input int o);
        return {r, a, d, 13'(o & 63)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        end
    endtask

    // Driver: one host access, returns the number of not-ready cycles.
    task automatic acc(input logic d, input logic w, input logic [1:0] b,
                       input logic [15:0] wd, output int waits);
        @(posedge clk); #1;
        cs = 1'b1; dsel = d; we = w; be = b; wdata = wd; waits = 0;
        forever begin
            @(negedge clk);
            if (rdy) break;
            waits++;
        end
        @(posedge clk); #1;
        cs = 1'b0; dsel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic d, input logic [1:0] b, input logic [15:0] e, input string tag);
        int w;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        acc(d, 1'b0, b, 16'h0, w);
    endtask

    task automatic wr(input logic d, input logic [1:0] b, input logic [15:0] wd);
        int w;
        acc(d, 1'b1, b, wd, w);
    endtask

    task automatic pload(input logic [15:0] v);
        wr(1'b0, 2'b11, v);
    endtask

    task automatic pchk(input logic [15:0] e, input string tag);
        rd(1'b0, 2'b11, e, tag);
    endtask

    // Monitor: every completed host read is compared with the scoreboard head.
    always @(negedge clk) begin
        if (cs && rdy && !we) begin
            if (exp_q.size() == 0) begin
                chk(0, "monitor", {16'h0, rdata}, 32'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata == e, t, {16'h0, rdata}, {16'h0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int w;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(rdy == 1'b1, "R1 idle ready", {31'h0, rdy}, 1);
        chk(err == 1'b0, "R1 err", {31'h0, err}, 0);
        pchk(16'h0000, "R1 pointer");

        txp = 2'd1; rxh = 2'd1;
        // Fill transmit packet 1 with bv(offset).
        pload(pw(0, 1, 0, 0));
        for (int i = 0; i < 8; i++) begin
            acc(1'b1, 1'b1, 2'b11, {bv(2*i+1), bv(2*i)}, w);
            if (i == 0) chk(w == 0, "R13 posted write", w, 0);
        end
        pchk(pw(0, 1, 0, 16), "R6 word advance");
        wr(1'b1, 2'b01, {8'hEE, bv(16)});
        wr(1'b1, 2'b10, {bv(17), 8'hEE});
        pchk(pw(0, 1, 0, 18), "R6 byte advance");

        // R4: a pointer load right after a word write waits for the drain.
        wr(1'b1, 2'b11, {bv(19), bv(18)});
        acc(1'b0, 1'b1, 2'b11, pw(0, 1, 1, 0), w);
        chk(w >= 1, "R4 load stalls", w, 1);

        rd(1'b1, 2'b11, {bv(1), bv(0)}, "R5 word");
        pchk(pw(0, 1, 1, 2), "R8 consumed address");
        rd(1'b1, 2'b11, {bv(3), bv(2)}, "R5 word");
        rd(1'b1, 2'b10, {bv(4), 8'h00}, "R5 high lane");
        rd(1'b1, 2'b01, {8'h00, bv(5)}, "R5 low lane");
        pchk(pw(0, 1, 1, 6), "R6 R8 readback");
        for (int o = 6; o < 20; o += 2) rd(1'b1, 2'b11, {bv(o+1), bv(o)}, "R5 stream");

        // R7: auto-increment off.
        pload(pw(0, 0, 1, 4));
        rd(1'b1, 2'b11, {bv(5), bv(4)}, "R7 repeat read");
        rd(1'b1, 2'b11, {bv(5), bv(4)}, "R7 repeat read");
        pchk(pw(0, 0, 1, 4), "R7 pointer held");
        chk(err == 1'b0, "R11 even load", {31'h0, err}, 0);
        pload(pw(0, 0, 0, 20));
        wr(1'b1, 2'b11, 16'h1111);
        wr(1'b1, 2'b11, 16'h2222);
        pchk(pw(0, 0, 0, 20), "R7 write pointer held");
        pload(pw(0, 1, 1, 20));
        rd(1'b1, 2'b11, 16'h2222, "R7 overwrite");

        // R11: odd offset with auto-increment off.
        pload(pw(0, 0, 1, 5));
        chk(err == 1'b1, "R11 odd load", {31'h0, err}, 1);
        pload(pw(0, 1, 1, 5));
        chk(err == 1'b0, "R11 cleared", {31'h0, err}, 0);

        // R12: stale prefetch is discarded.
        pload(pw(0, 1, 1, 0));
        repeat (8) @(posedge clk);
        pload(pw(0, 1, 1, 8));
        rd(1'b1, 2'b11, {bv(9), bv(8)}, "R12 flush");

        // R10: direction mismatch.
        acc(1'b1, 1'b1, 2'b11, 16'hDEAD, w);
        chk(w == 0, "R10 immediate", w, 0);
        pchk(pw(0, 1, 1, 10), "R10 pointer kept");
        pload(pw(0, 1, 1, 10));
        rd(1'b1, 2'b11, {bv(11), bv(10)}, "R10 memory kept");
        pload(pw(0, 1, 0, 30));
        rd(1'b1, 2'b11, 16'h0000, "R10 read in write mode");
        pchk(pw(0, 1, 0, 30), "R10 pointer kept");

        // R3: split pointer load.
        wr(1'b0, 2'b01, {8'h00, 8'h0C});
        pchk(pw(0, 1, 0, 30), "R3 low byte staged");
        wr(1'b0, 2'b10, {8'hE0, 8'h77});
        pchk(16'hE00C, "R3 high byte commits");
        rd(1'b1, 2'b11, {bv(13), bv(12)}, "R3 R9 receive area");

        // R9: packet number source.
        rxh = 2'd2;
        pload(pw(1, 1, 0, 8));
        wr(1'b1, 2'b11, 16'hBEEF);
        pload(pw(1, 1, 1, 8));
        rd(1'b1, 2'b11, 16'hBEEF, "R9 rx head 2");
        rxh = 2'd1;
        pload(pw(1, 1, 1, 8));
        rd(1'b1, 2'b11, {bv(9), bv(8)}, "R9 rx head 1");
        txp = 2'd2;
        pload(pw(0, 1, 1, 8));
        rd(1'b1, 2'b11, 16'hBEEF, "R9 tx number 2");
        txp = 2'd1;

        // R2: reserved bits.
        pload(16'h7FFF);
        pchk(16'h603F, "R2 reserved zero");

        // R6: wraparound at the top of the offset range.
        pload(pw(0, 1, 0, 63));
        wr(1'b1, 2'b11, 16'h1234);
        pchk(pw(0, 1, 0, 1), "R6 wrap");
        pload(pw(0, 1, 1, 63));
        rd(1'b1, 2'b11, 16'h1234, "R6 wrap read");

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule